// File: doc/BRIEF.md
# Sensor Limit Alarm Status Register

This block watches a set of digitized sensor readings (five 8-bit voltage codes, one two's-complement temperature byte and two fan period counts) and compares each new measurement against limits that software programs through a small register port. Any reading that breaks its limit sets its own bit in a 16-bit alarm status register. The bit stays set until software reads the status register. The temperature channel uses a crossing detector with two thresholds. It raises its bit once when the reading climbs past the upper threshold, and once more when the reading later falls under the lower threshold. An external over-limit line feeds one more status bit.

Measurements enter through a valid/ready handshake. A refresh pacer paces them. `meas_ready` is low for `REFRESH_CYCLES` clock cycles after reset and after each accepted sample. It then rises and stays high until `meas_valid` is seen with it, so a source that presents data early is held back. The source must hold its data stable while `meas_valid` is high. A word counts as accepted only in a cycle where both signals are high. The last accepted readings can be read back, so reads between refreshes return the previous values. A configuration bit picks whether the shared input is handled as the fifth voltage or as the temperature.

Top module: `sensor_alarm_unit`

## Requirements
- R1: On each accepted sample, voltage channel i (i = 0..4) sets status bit i when its code is strictly above its upper limit (address 0x10+2i) or strictly below its lower limit (address 0x11+2i). A code equal to a limit sets nothing.
- R2: On an accepted sample with the temperature channel selected, status bit 5 sets once when the signed reading rises strictly above the upper threshold (0x1A). It does not set again while the reading stays above that threshold or between the two thresholds. It sets once more when the reading later drops strictly below the lower threshold (0x1B).
- R3: Fan j (j = 0..1) sets status bit 6+j on an accepted sample when its count is strictly above its limit (0x1C+j). A larger count means a slower fan.
- R4: Status bit 8 sets in any clock cycle in which `ext_alarm` is high.
- R5: Reading address 0x00 returns the status on `reg_rdata` one cycle after the read strobe and clears every bit. A bit set by an event in that same cycle remains set. Without a read, a set bit stays set even after its cause has gone away.
- R6: Comparisons happen only in cycles with `meas_valid` and `meas_ready` both high. `meas_ready` is low after reset and after each accepted sample, and rises once `REFRESH_CYCLES` cycles have passed. `meas_valid` raised while `meas_ready` is low has no effect.
- R7: Bit 0 of the configuration register (0x01) selects the shared channel. With the bit at 0, voltage 4 is compared and temperature is ignored. With the bit at 1, temperature is compared and voltage 4 is ignored.
- R8: After reset, the status reads 0 and the configuration reads 0. Voltage upper limits read 0xFF, voltage lower limits 0x00, the temperature upper threshold 0x7F, the lower threshold 0x80, and the fan limits 0xFF. These values produce no alarm.
- R9: Limit registers read back the values written. Addresses 0x20+i (voltage), 0x25 (temperature) and 0x26+j (fan) return the readings of the last accepted sample. Status bits 15:9 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | Measurement word offered |
| meas_ready | output | 1 | Refresh slot open; word accepted when valid is also high |
| meas_volt | input | 40 | Voltage codes, channel i at bits 8i+7:8i |
| meas_temp | input | 8 | Temperature, two's complement, 1 degree per step |
| meas_fan | input | 16 | Fan period counts, fan j at bits 8j+7:8j |
| ext_alarm | input | 1 | External monitor over-limit line |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |

## Verification
An alarm event and a status read can land on the same clock edge. Events are merged into the status as the read clears it. The bench provokes this by setting bit 1 with one sample, then raising `reg_rd` to the status address at the very edge where a second sample, breaking channel 0's limit, is accepted. The bench judges the result from two values: the read data must show only bit 1, and a second status read must return exactly bit 0. A lost event or a missed clear shows up in one of the two reads.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int unsigned ADDR_W       = 6;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h00;
  localparam logic [ADDR_W-1:0] A_CONFIG = 6'h01;
  // limits: per voltage an upper/lower pair, then temperature pair, then fans
  localparam int unsigned A_LIMIT_BASE = 'h10;
  // captured readings: voltages, temperature, fans
  localparam int unsigned A_READ_BASE  = 'h20;
endpackage

// File: rtl/sa_pacer.sv
module sa_pacer #(
  parameter int unsigned PERIOD = 48_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (ready_q) begin
      if (in_valid) ready_q <= 1'b0;
    end else if (cnt_q == CW'(PERIOD - 1)) begin
      cnt_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign in_ready = ready_q;
  assign accept   = ready_q & in_valid;

  // R6: an open slot is only closed by a handshake
  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);
  // R6: after a handshake the slot stays shut for at least one cycle
  p_ready_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
endmodule

// File: rtl/sa_window_cmp.sv
module sa_window_cmp #(
  parameter int unsigned W         = 8,
  parameter bit          IS_SIGNED = 1'b0
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         above,
  output logic         below
);
  generate
    if (IS_SIGNED) begin : g_signed
      assign above = $signed(value) > $signed(hi);
      assign below = $signed(value) < $signed(lo);
    end else begin : g_unsigned
      assign above = value > hi;
      assign below = value < lo;
    end
  endgenerate
endmodule

// File: rtl/sa_temp_xing.sv
module sa_temp_xing (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic above,
  input  logic below,
  output logic evt
);
  logic hot_q;

  // fire on entering the hot band, then on leaving through the lower threshold
  assign evt = strobe && (hot_q ? below : above);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hot_q <= 1'b0;
    else if (evt) hot_q <= ~hot_q;
  end

  // R2: every crossing event flips the band state
  p_xing_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (hot_q != $past(hot_q)));
  // R2: without a sample the band state holds
  p_xing_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(hot_q));
endmodule

// File: rtl/sa_regs.sv
module sa_regs
  import sa_pkg::*;
#(
  parameter int unsigned NUM_V   = 5,
  parameter int unsigned NUM_FAN = 2,
  parameter int unsigned V_W     = 8,
  parameter int unsigned T_W     = 8,
  parameter int unsigned FAN_W   = 8,
  parameter int unsigned DW      = 16,
  parameter int unsigned SW      = NUM_V + NUM_FAN + 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic                             reg_rd,
  input  logic [ADDR_W-1:0]                reg_addr,
  input  logic [DW-1:0]                    reg_wdata,
  output logic [DW-1:0]                    reg_rdata,
  input  logic                             accept,
  input  logic [NUM_V*V_W-1:0]             meas_volt,
  input  logic [T_W-1:0]                   meas_temp,
  input  logic [NUM_FAN*FAN_W-1:0]         meas_fan,
  input  logic [SW-1:0]                    evt,
  output logic [NUM_V-1:0][V_W-1:0]        vmax,
  output logic [NUM_V-1:0][V_W-1:0]        vmin,
  output logic [T_W-1:0]                   tmax,
  output logic [T_W-1:0]                   tmin,
  output logic [NUM_FAN-1:0][FAN_W-1:0]    fan_lim,
  output logic                             temp_sel,
  output logic [SW-1:0]                    status
);
  localparam int unsigned A_TMAX  = A_LIMIT_BASE + 2 * NUM_V;
  localparam int unsigned A_TMIN  = A_TMAX + 1;
  localparam int unsigned A_FANL  = A_TMIN + 1;
  localparam int unsigned A_TREAD = A_READ_BASE + NUM_V;
  localparam int unsigned A_FREAD = A_TREAD + 1;

  logic [NUM_V-1:0][V_W-1:0]     vmax_q, vmin_q, vread_q;
  logic [NUM_FAN-1:0][FAN_W-1:0] flim_q, fread_q;
  logic [T_W-1:0]                tmax_q, tmin_q, tread_q;
  logic                          sel_q;
  logic [SW-1:0]                 status_q;
  logic [DW-1:0]                 rdata_q, rd_mux;
  logic                          rd_status;
  logic                          unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign rd_status    = reg_rd && (reg_addr == A_STATUS);

  // limit and configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmax_q <= '1;
      vmin_q <= '0;
      tmax_q <= {1'b0, {(T_W-1){1'b1}}};
      tmin_q <= {1'b1, {(T_W-1){1'b0}}};
      flim_q <= '1;
      sel_q  <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == A_CONFIG) sel_q <= reg_wdata[0];
      for (int i = 0; i < NUM_V; i++) begin
        if (reg_addr == ADDR_W'(A_LIMIT_BASE + 2 * i))     vmax_q[i] <= reg_wdata[V_W-1:0];
        if (reg_addr == ADDR_W'(A_LIMIT_BASE + 2 * i + 1)) vmin_q[i] <= reg_wdata[V_W-1:0];
      end
      if (reg_addr == ADDR_W'(A_TMAX)) tmax_q <= reg_wdata[T_W-1:0];
      if (reg_addr == ADDR_W'(A_TMIN)) tmin_q <= reg_wdata[T_W-1:0];
      for (int j = 0; j < NUM_FAN; j++) begin
        if (reg_addr == ADDR_W'(A_FANL + j)) flim_q[j] <= reg_wdata[FAN_W-1:0];
      end
    end
  end

  // readings of the last accepted sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vread_q <= '0;
      tread_q <= '0;
      fread_q <= '0;
    end else if (accept) begin
      vread_q <= meas_volt;
      tread_q <= meas_temp;
      fread_q <= meas_fan;
    end
  end

  // sticky status, cleared by a read, with same-cycle events merged in
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (rd_status) status_q <= evt;
    else                status_q <= status_q | evt;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_STATUS) rd_mux = DW'(status_q);
    if (reg_addr == A_CONFIG) rd_mux = DW'(sel_q);
    for (int i = 0; i < NUM_V; i++) begin
      if (reg_addr == ADDR_W'(A_LIMIT_BASE + 2 * i))     rd_mux = DW'(vmax_q[i]);
      if (reg_addr == ADDR_W'(A_LIMIT_BASE + 2 * i + 1)) rd_mux = DW'(vmin_q[i]);
      if (reg_addr == ADDR_W'(A_READ_BASE + i))          rd_mux = DW'(vread_q[i]);
    end
    if (reg_addr == ADDR_W'(A_TMAX))  rd_mux = DW'(tmax_q);
    if (reg_addr == ADDR_W'(A_TMIN))  rd_mux = DW'(tmin_q);
    if (reg_addr == ADDR_W'(A_TREAD)) rd_mux = DW'(tread_q);
    for (int j = 0; j < NUM_FAN; j++) begin
      if (reg_addr == ADDR_W'(A_FANL + j))  rd_mux = DW'(flim_q[j]);
      if (reg_addr == ADDR_W'(A_FREAD + j)) rd_mux = DW'(fread_q[j]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign vmax      = vmax_q;
  assign vmin      = vmin_q;
  assign tmax      = tmax_q;
  assign tmin      = tmin_q;
  assign fan_lim   = flim_q;
  assign temp_sel  = sel_q;
  assign status    = status_q;

  // R5: without a status read no set bit is lost
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_status |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R5: a status read with no new event leaves the register empty
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && (evt == '0)) |=> (status_q == '0));
  // R5: the read returns the value held before the clear
  p_read_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> (reg_rdata == DW'($past(status_q))));
endmodule

// File: rtl/sensor_alarm_unit.sv
module sensor_alarm_unit
  import sa_pkg::*;
#(
  parameter int unsigned NUM_V          = 5,
  parameter int unsigned NUM_FAN        = 2,
  parameter int unsigned V_W            = 8,
  parameter int unsigned T_W            = 8,
  parameter int unsigned FAN_W          = 8,
  parameter int unsigned DW             = 16,
  parameter int unsigned REFRESH_CYCLES = 48_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     meas_valid,
  output logic                     meas_ready,
  input  logic [NUM_V*V_W-1:0]     meas_volt,
  input  logic [T_W-1:0]           meas_temp,
  input  logic [NUM_FAN*FAN_W-1:0] meas_fan,
  input  logic                     ext_alarm,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata
);
  localparam int unsigned SW      = NUM_V + NUM_FAN + 2;
  localparam int unsigned B_TEMP  = NUM_V;
  localparam int unsigned B_FAN   = NUM_V + 1;
  localparam int unsigned B_EXT   = SW - 1;
  localparam int unsigned SHARED  = NUM_V - 1;

  logic                          accept;
  logic [NUM_V-1:0][V_W-1:0]     vmax, vmin;
  logic [T_W-1:0]                tmax, tmin;
  logic [NUM_FAN-1:0][FAN_W-1:0] fan_lim;
  logic                          temp_sel;
  logic [SW-1:0]                 evt, status;
  logic                          t_above, t_below;

  sa_pacer #(.PERIOD(REFRESH_CYCLES)) u_pacer (
    .clk(clk), .rst_n(rst_n), .in_valid(meas_valid),
    .in_ready(meas_ready), .accept(accept)
  );

  generate
    for (genvar i = 0; i < NUM_V; i++) begin : g_volt
      logic above, below, en;
      sa_window_cmp #(.W(V_W), .IS_SIGNED(1'b0)) u_cmp (
        .value(meas_volt[i*V_W +: V_W]), .lo(vmin[i]), .hi(vmax[i]),
        .above(above), .below(below)
      );
      if (i == SHARED) begin : g_shared
        assign en = accept && !temp_sel;
      end else begin : g_plain
        assign en = accept;
      end
      assign evt[i] = en && (above || below);
    end

    for (genvar j = 0; j < NUM_FAN; j++) begin : g_fan
      logic slow, unused_below;
      sa_window_cmp #(.W(FAN_W), .IS_SIGNED(1'b0)) u_cmp (
        .value(meas_fan[j*FAN_W +: FAN_W]), .lo({FAN_W{1'b0}}), .hi(fan_lim[j]),
        .above(slow), .below(unused_below)
      );
      assign evt[B_FAN + j] = accept && slow;
    end
  endgenerate

  sa_window_cmp #(.W(T_W), .IS_SIGNED(1'b1)) u_temp_cmp (
    .value(meas_temp), .lo(tmin), .hi(tmax), .above(t_above), .below(t_below)
  );

  sa_temp_xing u_xing (
    .clk(clk), .rst_n(rst_n), .strobe(accept && temp_sel),
    .above(t_above), .below(t_below), .evt(evt[B_TEMP])
  );

  assign evt[B_EXT] = ext_alarm;

  sa_regs #(
    .NUM_V(NUM_V), .NUM_FAN(NUM_FAN), .V_W(V_W), .T_W(T_W),
    .FAN_W(FAN_W), .DW(DW), .SW(SW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .accept(accept), .meas_volt(meas_volt), .meas_temp(meas_temp),
    .meas_fan(meas_fan), .evt(evt), .vmax(vmax), .vmin(vmin),
    .tmax(tmax), .tmin(tmin), .fan_lim(fan_lim), .temp_sel(temp_sel),
    .status(status)
  );

  // R6: outside a handshake no measurement bit can newly set
  p_strobe_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ((status[SW-2:0] & ~$past(status[SW-2:0])) == '0));
  // R4: the external line always leaves its bit set in the next cycle
  p_ext_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_alarm |=> status[B_EXT]);
endmodule

// File: tb/sensor_alarm_unit_tb.sv
module sensor_alarm_unit_tb;
  localparam int CLK_P  = 10;
  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        meas_valid = 1'b0;
  logic        meas_ready;
  logic [39:0] meas_volt = '0;
  logic [7:0]  meas_temp = '0;
  logic [15:0] meas_fan = '0;
  logic        ext_alarm = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sensor_alarm_unit #(.REFRESH_CYCLES(PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_volt(meas_volt), .meas_temp(meas_temp), .meas_fan(meas_fan),
    .ext_alarm(ext_alarm), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {volt v4..v0, temp, fan f1 f0, expected status}; limits: volt 0x40..0xC0,
  // temp 40..50, fan 0x80; config selects temperature (voltage 4 ignored)
  localparam logic [79:0] VEC [0:12] = '{
    {40'hFF_80_80_80_80, 8'h19, 16'h1010, 16'h0000}, // quiet
    {40'hFF_80_80_80_C1, 8'h19, 16'h1010, 16'h0001}, // R1 above
    {40'hFF_3F_80_80_80, 8'h19, 16'h1010, 16'h0008}, // R1 below
    {40'hFF_80_40_C0_80, 8'h19, 16'h1010, 16'h0000}, // R1 equal limits
    {40'hFF_80_80_80_80, 8'h33, 16'h1010, 16'h0020}, // R2 rise past 50
    {40'hFF_80_80_80_80, 8'h3C, 16'h1010, 16'h0000}, // R2 stays hot
    {40'hFF_80_80_80_80, 8'h2D, 16'h1010, 16'h0000}, // R2 in band
    {40'hFF_80_80_80_80, 8'h27, 16'h1010, 16'h0020}, // R2 drop under 40
    {40'hFF_80_80_80_80, 8'hF6, 16'h1010, 16'h0000}, // R2 negative, cool
    {40'hFF_80_80_80_80, 8'h19, 16'h1081, 16'h0040}, // R3 fan0 slow
    {40'hFF_80_80_80_80, 8'h19, 16'hFF80, 16'h0080}, // R3 fan1 slow, fan0 equal
    {40'hFF_80_FF_80_00, 8'h7F, 16'h1090, 16'h0065}, // R1 R2 R3 together
    {40'hFF_80_80_80_80, 8'h80, 16'h1010, 16'h0020}  // R2 drop to -128
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic sample(input logic [39:0] v, input logic [7:0] t, input logic [15:0] f);
    @(negedge clk);
    while (!meas_ready) @(negedge clk);
    meas_volt = v; meas_temp = t; meas_fan = f; meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  localparam logic [39:0] BASE = 40'hFF_80_80_80_80;

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 ready low after reset", {15'd0, meas_ready}, 16'h0000);
    rd(6'h00, d); check("R8 status reset", d, 16'h0000);
    rd(6'h01, d); check("R8 config reset", d, 16'h0000);
    rd(6'h10, d); check("R8 vmax0 reset", d, 16'h00FF);
    rd(6'h19, d); check("R8 vmin4 reset", d, 16'h0000);
    rd(6'h1A, d); check("R8 tmax reset", d, 16'h007F);
    rd(6'h1B, d); check("R8 tmin reset", d, 16'h0080);
    rd(6'h1D, d); check("R8 fan1 limit reset", d, 16'h00FF);

    for (int i = 0; i < 5; i++) begin
      wr(6'(8'h10 + 2 * i), 16'h00C0);
      wr(6'(8'h11 + 2 * i), 16'h0040);
    end
    wr(6'h1A, 16'h0032);
    wr(6'h1B, 16'h0028);
    wr(6'h1C, 16'h0080);
    wr(6'h1D, 16'h0080);
    wr(6'h01, 16'h0001);
    rd(6'h17, d); check("R9 vmin3 readback", d, 16'h0040);
    rd(6'h1B, d); check("R9 tmin readback", d, 16'h0028);

    for (int r = 0; r < 13; r++) begin
      sample(VEC[r][79:40], VEC[r][39:32], VEC[r][31:16]);
      rd(6'h00, d);
      check($sformatf("R1/R2/R3 table row %0d", r), d, VEC[r][15:0]);
    end

    rd(6'h20, d); check("R9 voltage0 reading", d, 16'h0080);
    rd(6'h25, d); check("R9 temperature reading", d, 16'h0080);
    rd(6'h27, d); check("R9 fan1 reading", d, 16'h0010);

    // R5: sticky after the cause goes away, then cleared
    sample(40'hFF_80_80_80_C1, 8'h19, 16'h1010);
    sample(BASE, 8'h19, 16'h1010);
    rd(6'h00, d); check("R5 sticky bit", d, 16'h0001);
    rd(6'h00, d); check("R5 cleared by read", d, 16'h0000);

    // R5: event on the same edge as the status read survives
    sample(40'hFF_80_80_C1_80, 8'h19, 16'h1010);
    @(negedge clk);
    while (!meas_ready) @(negedge clk);
    meas_volt = 40'hFF_80_80_80_C1; meas_valid = 1'b1;
    reg_rd = 1'b1; reg_addr = 6'h00;
    @(negedge clk);
    meas_valid = 1'b0; reg_rd = 1'b0;
    check("R5 read on event edge", reg_rdata, 16'h0002);
    rd(6'h00, d); check("R5 event kept through read", d, 16'h0001);

    // R6: valid without ready is ignored
    sample(BASE, 8'h19, 16'h1010);
    meas_volt = 40'hFF_80_80_80_FF; meas_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 ready low within refresh gap", {15'd0, meas_ready}, 16'h0000);
    meas_valid = 1'b0;
    repeat (PERIOD + 2) @(negedge clk);
    rd(6'h00, d); check("R6 early valid ignored", d, 16'h0000);
    rd(6'h20, d); check("R6 reading not captured", d, 16'h0080);

    // R7: shared channel selection
    wr(6'h01, 16'h0000);
    sample(BASE, 8'h64, 16'h1010);
    rd(6'h00, d); check("R7 voltage4 selected", d, 16'h0010);
    wr(6'h01, 16'h0001);
    sample(BASE, 8'h64, 16'h1010);
    rd(6'h00, d); check("R7 temperature selected", d, 16'h0020);

    // R4: external line
    @(negedge clk); ext_alarm = 1'b1;
    @(negedge clk); ext_alarm = 1'b0;
    rd(6'h00, d); check("R4 external bit", d, 16'h0100);
    rd(6'h00, d); check("R4 external cleared", d, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL R6 watchdog expired got hang expected completion");
      summary();
      $finish;
    end
  end
endmodule